// File: doc/BRIEF.md
# Direct-Mapped Word Cache with Selectable Write Policy

This block is a direct-mapped data cache placed between a processor load/store port and a word-wide backing memory. A request carries a byte address, a read/write flag and write data. The cache splits the address arithmetically into a tag, a set number and a word-within-line offset. It answers hits from its own storage, and it fetches or writes back whole lines one word at a time on a simple request/acknowledge memory port. The number of sets and the number of words per line are parameters.

A one-bit policy input picks the write policy, and it is sampled when each request or flush is accepted. In write-through mode every store also reaches memory. In write-back mode a store only marks the line dirty, and the dirty line goes back to memory when it is replaced or flushed. Write misses allocate the line: the line is filled first and the stored word is merged into it. A flush command walks every set, writes back the dirty lines under write-back policy, and leaves every line invalid. Two wrapping counters record hits and misses. Each accepted access bumps exactly one of them.

Top module: `dm_cache`

## Requirements
- R1: A byte address A maps to word address W = A/4. The tag is W/(SETS·WORDS), the set is (W mod (SETS·WORDS))/WORDS, and the offset is W mod WORDS. An access is a hit only when that set is valid and holds that tag.
- R2: Each accepted request increments exactly one counter: `hit_count` on a hit, `miss_count` on a miss. A cycle with no accepted request leaves both counters unchanged.
- R3: On a miss, the cache issues exactly WORDS memory reads, at the line base address plus 4·k for k = 0..WORDS-1 in order. A read returns the current value of the addressed word. A hit issues no memory reads.
- R4: When `pol_wb` = 0 (write-through), every write issues one memory write of the same word to the same address, and it completes before `rsp_valid`.
- R5: When `pol_wb` = 1 (write-back), a write issues no memory write. Replacing a valid dirty line issues WORDS memory writes at addresses rebuilt from the stored tag and set, before the new line is fetched.
- R6: A write miss allocates the line. After it, the written word reads back as the new data and the other words of the line read back as memory held them.
- R7: A flush accepted on `flush_req` writes back every valid dirty line when `pol_wb` = 1 and then invalidates all sets. `flush_done` pulses for one cycle at the end. Afterwards memory holds every written value and the next access misses.
- R8: `req_ready` is low whenever the block is busy. A read hit, or a write hit under write-back policy, raises `rsp_valid` for exactly one cycle, in the cycle after the accepting edge.
- R9: After reset, no line is valid, both counters are zero, `req_ready` is high, and `rsp_valid` and `mem_req` are low.
- R10: With 4 sets of 4 words under write-through policy, the sequence reads 0x200, 0x204, 0x21C, 0x300 twice, then writes 0x700 twice. It ends with 4 hits and 6 misses.
- R11: Under write-through policy, replacing a dirty line issues no memory writes. The only memory write for an access is the store itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_wb | input | 1 | Write policy: 1 write-back, 0 write-through; sampled on accept |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 store, 0 load |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse for every access |
| rsp_rdata | output | DW | Load data, valid with rsp_valid |
| flush_req | input | 1 | Flush command; taken when idle, ahead of a request |
| flush_done | output | 1 | One-cycle pulse when the flush ends |
| mem_req | output | 1 | Memory word transaction, held until mem_ack |
| mem_write | output | 1 | 1 memory write, 0 memory read |
| mem_addr | output | AW | Memory byte address, word aligned |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory completes the current word |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |
| hit_count | output | CW | Wrapping hit counter |
| miss_count | output | CW | Wrapping miss counter |

## Verification
Both counters change at the accepting edge. A hit that needs no memory traffic raises `rsp_valid` in the cycle right after that edge. Every miss takes a number of memory word transactions that the bench predicts from its own line model, and the model memory needs two cycles per word. The bench samples at falling edges. It waits on `rsp_valid` or `flush_done` instead of fixed delays. It checks that `req_ready` stays low while it waits, and it requires a latency of exactly one cycle for hits. Memory contents, write and read counts and the logged fill addresses are compared once the response pulse is seen, which is after the edge that performed the last memory word.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WBACK,
    ST_FILL,
    ST_WTHRU,
    ST_RESP,
    ST_FLUSH
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int SETS = 4,
  parameter int IW   = 2,
  parameter int TW   = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_valid,
  output logic          rd_dirty,
  output logic [TW-1:0] rd_tag,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_valid,
  input  logic          wr_dirty,
  input  logic [TW-1:0] wr_tag
);
  logic          valid_q [SETS];
  logic          dirty_q [SETS];
  logic [TW-1:0] tag_q   [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic sel;
    assign sel = wr_en && (wr_idx == IW'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[s] <= 1'b0;
        dirty_q[s] <= 1'b0;
      end else if (sel) begin
        valid_q[s] <= wr_valid;
        dirty_q[s] <= wr_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) tag_q[s] <= wr_tag;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int DEPTH = 16,
  parameter int DAW   = 4,
  parameter int DW    = 32
) (
  input  logic           clk,
  input  logic           we,
  input  logic [DAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [DAW-1:0] ra_addr,
  output logic [DW-1:0]  ra_data,
  input  logic [DAW-1:0] rb_addr,
  output logic [DW-1:0]  rb_data
);
  logic [DW-1:0] word_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) word_q[waddr] <= wdata;
  end

  assign ra_data = word_q[ra_addr];
  assign rb_data = word_q[rb_addr];
endmodule

// File: rtl/dmc_counters.sv
module dmc_counters #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_hit,
  input  logic          inc_miss,
  output logic [CW-1:0] hit_count,
  output logic [CW-1:0] miss_count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      if (inc_hit)  hit_count  <= hit_count + CW'(1);
      if (inc_miss) miss_count <= miss_count + CW'(1);
    end
  end
endmodule

// File: rtl/dm_cache.sv
module dm_cache
  import dmc_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WORDS = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pol_wb,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic          flush_req,
  output logic          flush_done,
  output logic          mem_req,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic [CW-1:0] hit_count,
  output logic [CW-1:0] miss_count
);
  localparam int WAW   = AW - 2;
  localparam int TW    = WAW;
  localparam int IW    = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int OW    = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int LINEW = SETS * WORDS;
  localparam int DAW   = (LINEW > 1) ? $clog2(LINEW) : 1;

  function automatic logic [AW-1:0] line_word_addr(input logic [TW-1:0] t,
                                                   input logic [IW-1:0] i,
                                                   input logic [OW-1:0] k);
    logic [WAW-1:0] wa;
    wa = t * WAW'(LINEW) + WAW'(i) * WAW'(WORDS) + WAW'(k);
    return {wa, 2'b00};
  endfunction

  function automatic logic [DAW-1:0] store_idx(input logic [IW-1:0] i,
                                               input logic [OW-1:0] k);
    return DAW'(int'(i) * WORDS + int'(k));
  endfunction

  // address split
  logic [WAW-1:0] in_wa;
  logic [TW-1:0]  in_tag;
  logic [IW-1:0]  in_idx;
  logic [OW-1:0]  in_off;
  logic           unused_bits;
  assign in_wa       = req_addr[AW-1:2];
  assign in_tag      = TW'(in_wa / WAW'(LINEW));
  assign in_idx      = IW'((in_wa % WAW'(LINEW)) / WAW'(WORDS));
  assign in_off      = OW'(in_wa % WAW'(WORDS));
  assign unused_bits = ^req_addr[1:0];

  // state
  dmc_state_e    state_q, state_d;
  logic          r_write_q, r_write_d, r_wb_q, r_wb_d;
  logic [TW-1:0] r_tag_q, r_tag_d;
  logic [IW-1:0] r_idx_q, r_idx_d, fset_q, fset_d;
  logic [OW-1:0] r_off_q, r_off_d, wcnt_q, wcnt_d;
  logic [DW-1:0] r_wdata_q, r_wdata_d;

  // storage interfaces
  logic [IW-1:0]  look_idx, ts_idx;
  logic           lk_valid, lk_dirty, lk_hit;
  logic [TW-1:0]  lk_tag, ts_tag;
  logic           ts_we, ts_valid, ts_dirty;
  logic           ds_we;
  logic [DAW-1:0] ds_addr;
  logic [DW-1:0]  ds_wdata, rb_data;
  logic           inc_hit, inc_miss, flush_step, last_word, last_set;

  assign look_idx  = (state_q == ST_IDLE)  ? in_idx :
                     (state_q == ST_FLUSH) ? fset_q : r_idx_q;
  assign lk_hit    = lk_valid && (lk_tag == in_tag);
  assign last_word = (wcnt_q == OW'(WORDS - 1));
  assign last_set  = (fset_q == IW'(SETS - 1));
  assign req_ready = (state_q == ST_IDLE) && !flush_req;

  dmc_tag_store #(.SETS(SETS), .IW(IW), .TW(TW)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (look_idx),
    .rd_valid (lk_valid),
    .rd_dirty (lk_dirty),
    .rd_tag   (lk_tag),
    .wr_en    (ts_we),
    .wr_idx   (ts_idx),
    .wr_valid (ts_valid),
    .wr_dirty (ts_dirty),
    .wr_tag   (ts_tag)
  );

  dmc_data_store #(.DEPTH(LINEW), .DAW(DAW), .DW(DW)) u_data (
    .clk     (clk),
    .we      (ds_we),
    .waddr   (ds_addr),
    .wdata   (ds_wdata),
    .ra_addr (store_idx(r_idx_q, r_off_q)),
    .ra_data (rsp_rdata),
    .rb_addr (store_idx((state_q == ST_FLUSH) ? fset_q : r_idx_q, wcnt_q)),
    .rb_data (rb_data)
  );

  dmc_counters #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_hit    (inc_hit),
    .inc_miss   (inc_miss),
    .hit_count  (hit_count),
    .miss_count (miss_count)
  );

  // next state and outputs
  always_comb begin
    state_d    = state_q;
    r_write_d  = r_write_q;
    r_wb_d     = r_wb_q;
    r_tag_d    = r_tag_q;
    r_idx_d    = r_idx_q;
    r_off_d    = r_off_q;
    r_wdata_d  = r_wdata_q;
    wcnt_d     = wcnt_q;
    fset_d     = fset_q;
    ts_we      = 1'b0;
    ts_idx     = r_idx_q;
    ts_valid   = 1'b1;
    ts_dirty   = 1'b0;
    ts_tag     = r_tag_q;
    ds_we      = 1'b0;
    ds_addr    = store_idx(r_idx_q, wcnt_q);
    ds_wdata   = mem_rdata;
    mem_req    = 1'b0;
    mem_write  = 1'b0;
    mem_addr   = line_word_addr(r_tag_q, r_idx_q, wcnt_q);
    mem_wdata  = rb_data;
    rsp_valid  = 1'b0;
    flush_done = 1'b0;
    flush_step = 1'b0;
    inc_hit    = 1'b0;
    inc_miss   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (flush_req) begin
          state_d = ST_FLUSH;
          fset_d  = '0;
          wcnt_d  = '0;
          r_wb_d  = pol_wb;
        end else if (req_valid) begin
          r_write_d = req_write;
          r_wb_d    = pol_wb;
          r_tag_d   = in_tag;
          r_idx_d   = in_idx;
          r_off_d   = in_off;
          r_wdata_d = req_wdata;
          wcnt_d    = '0;
          if (lk_hit) begin
            inc_hit = 1'b1;
            state_d = ST_RESP;
            if (req_write) begin
              ds_we    = 1'b1;
              ds_addr  = store_idx(in_idx, in_off);
              ds_wdata = req_wdata;
              ts_we    = 1'b1;
              ts_idx   = in_idx;
              ts_dirty = 1'b1;
              ts_tag   = in_tag;
              if (!pol_wb) state_d = ST_WTHRU;
            end
          end else begin
            inc_miss = 1'b1;
            state_d  = (lk_valid && lk_dirty && pol_wb) ? ST_WBACK : ST_FILL;
          end
        end
      end
      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_write = 1'b1;
        mem_addr  = line_word_addr(lk_tag, r_idx_q, wcnt_q);
        if (mem_ack) begin
          wcnt_d = wcnt_q + OW'(1);
          if (last_word) begin
            wcnt_d  = '0;
            state_d = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          ds_we    = 1'b1;
          ds_wdata = (r_write_q && (wcnt_q == r_off_q)) ? r_wdata_q : mem_rdata;
          wcnt_d   = wcnt_q + OW'(1);
          if (last_word) begin
            ts_we    = 1'b1;
            ts_dirty = r_write_q;
            wcnt_d   = '0;
            state_d  = (r_write_q && !r_wb_q) ? ST_WTHRU : ST_RESP;
          end
        end
      end
      ST_WTHRU: begin
        mem_req   = 1'b1;
        mem_write = 1'b1;
        mem_addr  = line_word_addr(r_tag_q, r_idx_q, r_off_q);
        mem_wdata = r_wdata_q;
        if (mem_ack) state_d = ST_RESP;
      end
      ST_RESP: begin
        rsp_valid = 1'b1;
        state_d   = ST_IDLE;
      end
      ST_FLUSH: begin
        if (lk_valid && lk_dirty && r_wb_q) begin
          mem_req   = 1'b1;
          mem_write = 1'b1;
          mem_addr  = line_word_addr(lk_tag, fset_q, wcnt_q);
          if (mem_ack) begin
            if (last_word) flush_step = 1'b1;
            else           wcnt_d = wcnt_q + OW'(1);
          end
        end else begin
          flush_step = 1'b1;
        end
        if (flush_step) begin
          ts_we    = 1'b1;
          ts_idx   = fset_q;
          ts_valid = 1'b0;
          ts_dirty = 1'b0;
          ts_tag   = lk_tag;
          wcnt_d   = '0;
          if (last_set) begin
            state_d    = ST_IDLE;
            flush_done = 1'b1;
          end else begin
            fset_d = fset_q + IW'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      r_write_q <= 1'b0;
      r_wb_q    <= 1'b0;
      r_tag_q   <= '0;
      r_idx_q   <= '0;
      r_off_q   <= '0;
      r_wdata_q <= '0;
      wcnt_q    <= '0;
      fset_q    <= '0;
    end else begin
      state_q   <= state_d;
      r_write_q <= r_write_d;
      r_wb_q    <= r_wb_d;
      r_tag_q   <= r_tag_d;
      r_idx_q   <= r_idx_d;
      r_off_q   <= r_off_d;
      r_wdata_q <= r_wdata_d;
      wcnt_q    <= wcnt_d;
      fset_q    <= fset_d;
    end
  end
endmodule

// File: rtl/dm_cache_chk.sv
module dm_cache_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic [CW-1:0] hit_count,
  input logic [CW-1:0] miss_count
);
  // R2
  one_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (CW'(hit_count + miss_count - $past(hit_count) - $past(miss_count)) == CW'(1)));

  // R2
  quiet_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> ($stable(hit_count) && $stable(miss_count)));

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_write)));
endmodule

bind dm_cache dm_cache_chk #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/dm_cache_tb.sv
module dm_cache_tb;
  localparam int SETS = 4, WORDS = 4, LINEW = SETS * WORDS;
  localparam int AW = 32, DW = 32, CW = 16;

  logic clk, rst_n, pol_wb;
  logic req_valid, req_ready, req_write, rsp_valid, flush_req, flush_done;
  logic [AW-1:0] req_addr, mem_addr;
  logic [DW-1:0] req_wdata, rsp_rdata, mem_wdata, mem_rdata;
  logic mem_req, mem_write, mem_ack;
  logic [CW-1:0] hit_count, miss_count;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  dm_cache #(.SETS(SETS), .WORDS(WORDS), .AW(AW), .DW(DW), .CW(CW)) u_dut (.*);

  // memory model: two cycles per word
  logic [31:0] mem_m [1024];
  logic [31:0] rlog [16];
  logic ack_q;
  int mwr_cnt, mrd_cnt;

  function automatic logic [31:0] init_word(input int i);
    return 32'h5A00_0000 ^ (i * 32'h0001_0003);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      mwr_cnt <= 0;
      mrd_cnt <= 0;
      for (int i = 0; i < 1024; i++) mem_m[i] <= init_word(i);
    end else begin
      ack_q <= mem_req && !ack_q;
      if (mem_req && ack_q) begin
        if (mem_write) begin
          mem_m[mem_addr[11:2]] <= mem_wdata;
          mwr_cnt <= mwr_cnt + 1;
        end else begin
          rlog[mrd_cnt % 16] <= mem_addr;
          mrd_cnt <= mrd_cnt + 1;
        end
      end
    end
  end
  assign mem_ack   = ack_q;
  assign mem_rdata = mem_m[mem_addr[11:2]];

  // bench model
  logic [31:0] gm [1024];
  logic bval [SETS];
  logic bdirty [SETS];
  int btag [SETS];
  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input int a, input logic [31:0] d, output logic [31:0] rd);
    int wa, t, s, o, base, exp_wr, exp_rd, h0, m0, w0, r0, lat;
    logic hit, busy_bad;
    wa = a / 4; t = wa / LINEW; s = (wa % LINEW) / WORDS; o = wa % WORDS;
    base = (wa - o) * 4;
    hit = bval[s] && (btag[s] == t);
    exp_rd = hit ? 0 : WORDS;
    exp_wr = ((!hit && bval[s] && bdirty[s] && pol_wb) ? WORDS : 0) + ((w && !pol_wb) ? 1 : 0);
    h0 = int'(hit_count); m0 = int'(miss_count); w0 = mwr_cnt; r0 = mrd_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; lat = 1; busy_bad = 1'b0;
    while (!rsp_valid) begin
      if (req_ready) busy_bad = 1'b1;
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    chk("R1 hit count", int'(hit_count) - h0, {31'd0, hit});
    chk("R2 miss count", int'(miss_count) - m0, {31'd0, !hit});
    chk("R8 ready low while busy", {31'd0, busy_bad}, 0);
    if (hit && (!w || pol_wb)) chk("R8 hit latency", lat, 1);
    if (!w) chk("R3 read data", rd, gm[wa]);
    if (pol_wb) chk("R5 memory writes", mwr_cnt - w0, exp_wr);
    else        chk("R11 memory writes", mwr_cnt - w0, exp_wr);
    chk("R3 fill reads", mrd_cnt - r0, exp_rd);
    if (!hit)
      for (int k = 0; k < WORDS; k++) chk("R3 fill address", rlog[(r0 + k) % 16], base + 4 * k);
    if (w) gm[wa] = d;
    if (w && !pol_wb) chk("R4 memory word", mem_m[wa], d);
    if (!hit) begin
      bval[s] = 1'b1; btag[s] = t; bdirty[s] = w;
    end else begin
      bdirty[s] = bdirty[s] | w;
    end
  endtask

  task automatic do_flush();
    int w0, expw, n;
    expw = 0;
    for (int s = 0; s < SETS; s++) if (bval[s] && bdirty[s] && pol_wb) expw += WORDS;
    w0 = mwr_cnt;
    @(negedge clk); flush_req = 1'b1;
    @(negedge clk); flush_req = 1'b0;
    n = 0;
    while (!flush_done && n < 1000) begin @(negedge clk); n++; end
    chk("R7 done pulse", {31'd0, flush_done}, 1);
    @(negedge clk);
    chk("R7 write-back count", mwr_cnt - w0, expw);
    n = 0;
    for (int i = 0; i < 1024; i++) if (mem_m[i] !== gm[i]) n++;
    chk("R7 memory image", n, 0);
    for (int s = 0; s < SETS; s++) begin bval[s] = 1'b0; bdirty[s] = 1'b0; end
  endtask

  function automatic int mk_addr(input int t, input int s, input int o);
    return (t * LINEW + s * WORDS + o) * 4;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R8 actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int h0, m0;
    rst_n = 1'b0; pol_wb = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; flush_req = 1'b0;
    for (int i = 0; i < 1024; i++) gm[i] = init_word(i);
    for (int s = 0; s < SETS; s++) begin bval[s] = 1'b0; bdirty[s] = 1'b0; btag[s] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 ready", {31'd0, req_ready}, 1);
    chk("R9 rsp_valid", {31'd0, rsp_valid}, 0);
    chk("R9 mem_req", {31'd0, mem_req}, 0);
    chk("R9 hit_count", {16'd0, hit_count}, 0);
    chk("R9 miss_count", {16'd0, miss_count}, 0);

    // R10 reference sequence, write-through
    pol_wb = 1'b0;
    for (int r = 0; r < 2; r++) begin
      acc(1'b0, 32'h200, 0, rd);
      acc(1'b0, 32'h204, 0, rd);
      acc(1'b0, 32'h21C, 0, rd);
      acc(1'b0, 32'h300, 0, rd);
    end
    acc(1'b1, 32'h700, 32'h24, rd);
    acc(1'b1, 32'h700, 32'h23, rd);
    chk("R10 hits", {16'd0, hit_count}, 4);
    chk("R10 misses", {16'd0, miss_count}, 6);

    // write-back sweep
    pol_wb = 1'b1;
    for (int i = 0; i < 64; i++)
      acc((i % 3) == 0, mk_addr(8 + (i * 7) % 5, (i * 3) % SETS, (i * 5) % WORDS),
          32'hA000 + i * 32'h1111, rd);
    do_flush();

    // R7 next access misses
    h0 = int'(hit_count); m0 = int'(miss_count);
    acc(1'b0, mk_addr(8, 0, 0), 0, rd);
    chk("R7 miss after flush", int'(miss_count) - m0, 1);
    chk("R7 no hit after flush", int'(hit_count) - h0, 0);

    // R6 write miss allocation
    acc(1'b1, mk_addr(9, 2, 2), 32'hCAFE_0002, rd);
    for (int k = 0; k < WORDS; k++) begin
      acc(1'b0, mk_addr(9, 2, k), 0, rd);
      chk("R6 line word", rd, gm[mk_addr(9, 2, k) / 4]);
    end
    do_flush();

    // write-through sweep: dirty lines dropped without write-back
    pol_wb = 1'b0;
    for (int i = 0; i < 48; i++)
      acc((i % 2) == 0, mk_addr(10 + (i * 3) % 4, (i * 5) % SETS, (i * 7) % WORDS),
          32'hB000 + i * 32'h0101, rd);
    do_flush();

    summary();
    $finish;
  end
endmodule